// File: doc/BRIEF.md
# Signed Saturating Up/Down Counter

This block keeps a signed two's complement count and moves it by one step on each enabled clock. One direction input picks the step: high moves the count up and low moves it down. At either end of the signed range the count clamps and does not wrap. Once the count reaches the most positive code, further up steps leave it unchanged. Once it reaches the most negative code, further down steps leave it unchanged. Two flags show when the count sits at either limit. This lets surrounding logic use the counter as a small signed confidence or hysteresis state.

The width is a parameter, `CNT_W`, with a minimum of 2 and a default of 2. With the default the range runs from -2 to +1. A clock enable freezes the count, and a synchronous active-low reset returns it to zero.

Top module: `sat_updn_ctr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0 on that edge, whatever `en` and `up_dn` are.
- R2: With `en` high, `up_dn` = 1 and the count below the most positive code (2^(CNT_W-1)-1), the count rises by exactly one on the next edge.
- R3: With `en` high, `up_dn` = 0 and the count above the most negative code (-2^(CNT_W-1)), the count falls by exactly one on the next edge.
- R4: With `en` high, `up_dn` = 1 and the count at the most positive code (binary 01 for the default width), the count stays at that code and never changes to the most negative code.
- R5: With `en` high, `up_dn` = 0 and the count at the most negative code (binary 10 for the default width), the count stays at that code and never changes to the most positive code.
- R6: With `en` low, the count holds its value on the next edge for either value of `up_dn`.
- R7: `at_max` is 1 exactly when the count equals the most positive code, and `at_min` is 1 exactly when the count equals the most negative code. The two flags are never high together.
- R8: `count` is presented as a signed two's complement value that is `CNT_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the count to 0 |
| en | input | 1 | Clock enable; when low the count holds |
| up_dn | input | 1 | Step direction: 1 counts up, 0 counts down |
| count | output | CNT_W | Signed two's complement count |
| at_max | output | 1 | High while the count is the most positive code |
| at_min | output | 1 | High while the count is the most negative code |

## Verification
The cases that are hardest to reach are a step that pushes against a limit and an enable drop that lands while the count sits at a limit. The count must first be walked to the end of the range, and the step must then be applied again there. The stimulus drives long runs in one direction, each longer than the full range, so the count reaches each end and then holds against it for several cycles. Alternating and random direction patterns follow, with the enable toggled at random, so that held cycles occur both at the limits and between them. A behavioural integer model with explicit clamping checks every cycle.

// File: rtl/sat_ctr_pkg.sv
// Package: shared helpers for the saturating counter.
// Assumes: widths of at least 2 bits.
package sat_ctr_pkg;
    // Step decision taken by the next-state logic each cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10
    } step_e;
endpackage

// File: rtl/sat_limit_det.sv
// Module: sat_limit_det
// Purpose: flags whether a signed value equals the most positive or
//          the most negative code of its width.
// Assumes: W >= 2; value is two's complement.
module sat_limit_det #(
    parameter int W = 2
) (
    input  logic signed [W-1:0] val,
    output logic                is_max,
    output logic                is_min
);
    localparam logic signed [W-1:0] MAX_CODE = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};

    // Compare against both limit codes.
    always_comb begin
        is_max = (val == MAX_CODE);
        is_min = (val == MIN_CODE);
    end
endmodule

// File: rtl/sat_step_sel.sv
// Module: sat_step_sel
// Purpose: chooses the step for the next cycle from the enable, the
//          direction and the limit flags, so the count never wraps.
// Assumes: flags come from sat_limit_det on the current count.
module sat_step_sel
    import sat_ctr_pkg::*;
(
    input  logic  en,
    input  logic  up_dn,
    input  logic  is_max,
    input  logic  is_min,
    output step_e step
);
    // Pick the step, and hold when it would cross a limit.
    always_comb begin
        if (!en)
            step = STEP_HOLD;
        else if (up_dn)
            step = is_max ? STEP_HOLD : STEP_INC;
        else
            step = is_min ? STEP_HOLD : STEP_DEC;
    end
endmodule

// File: rtl/sat_updn_ctr.sv
// Module: sat_updn_ctr
// Purpose: signed up/down counter that clamps at the ends of its range
//          instead of wrapping; it reports when it is at either limit.
// Assumes: CNT_W >= 2; rst_n is synchronous and active low.
module sat_updn_ctr
    import sat_ctr_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    up_dn,
    output logic signed [CNT_W-1:0] count,
    output logic                    at_max,
    output logic                    at_min
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    logic  hit_max;
    logic  hit_min;
    step_e step;

    // Width guard.
    initial begin
        width_ok_chk: assert (CNT_W >= 2)
            else $error("CNT_W must be at least 2");
    end

    sat_limit_det #(.W(CNT_W)) u_lim (
        .val    (count),
        .is_max (hit_max),
        .is_min (hit_min)
    );

    sat_step_sel u_sel (
        .en     (en),
        .up_dn  (up_dn),
        .is_max (hit_max),
        .is_min (hit_min),
        .step   (step)
    );

    // Count register: clear on reset, otherwise apply the chosen step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else begin
            case (step)
                STEP_INC: count <= count + ONE;
                STEP_DEC: count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

    // Drive the limit flags from the detector.
    always_comb begin
        at_max = hit_max;
        at_min = hit_min;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up_dn && at_max) |=> (at_max && $stable(count)));
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up_dn && at_min) |=> (at_min && $stable(count)));
    // R6
    hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_max && at_min));
    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up_dn && !at_max) |=> (count == $past(count) + ONE));
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !up_dn && !at_min) |=> (count == $past(count) - ONE));
endmodule

// File: tb/sat_updn_ctr_tb.sv
// Bench: drives sat_updn_ctr and checks it against a behavioural integer
// model every clock.
module sat_updn_ctr_tb;
    localparam int W    = 2;
    localparam int VMAX = (1 << (W-1)) - 1;
    localparam int VMIN = -(1 << (W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic up_dn = 1'b0;
    logic signed [W-1:0] count;
    logic at_max, at_min;

    int n_chk = 0;
    int n_fail = 0;
    int model = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sat_updn_ctr #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .up_dn(up_dn),
        .count(count), .at_max(at_max), .at_min(at_min)
    );

    // Advance the model at each edge from the inputs seen there.
    always @(posedge clk) begin
        if (!rst_n) model <= 0;
        else if (en && up_dn && model < VMAX) model <= model + 1;
        else if (en && !up_dn && model > VMIN) model <= model - 1;
    end

    // Compare mid-cycle, after outputs settle.
    task automatic check(input string tag);
        int got;
        @(negedge clk);
        got = int'(count);
        n_chk++;
        if (got != model || at_max != (model == VMAX) || at_min != (model == VMIN)) begin
            n_fail++;
            $display("FAIL %s: count=%0d max=%0b min=%0b expected count=%0d max=%0b min=%0b",
                     tag, got, at_max, at_min, model, model == VMAX, model == VMIN);
        end
    endtask

    task automatic drive(input bit e, input bit d, input string tag);
        en = e; up_dn = d;
        check(tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with the inputs active.
        en = 1'b1; up_dn = 1'b1;
        check("R1 reset");
        check("R1 reset held");
        rst_n = 1'b1;
        // R2 then R4: count up past the maximum and hold against it.
        for (int i = 0; i < 6; i++) drive(1, 1, i < 1 ? "R2 inc" : "R4 clamp max R7");
        // R6 at the maximum, with the direction switched.
        drive(0, 0, "R6 hold at max");
        drive(0, 1, "R6 hold at max");
        // R3 then R5: count down to the minimum and hold against it.
        for (int i = 0; i < 7; i++) drive(1, 0, i < 3 ? "R3 dec" : "R5 clamp min R7");
        drive(0, 1, "R6 hold at min");
        // R8: alternating steps in the middle of the range.
        for (int i = 0; i < 8; i++) drive(1, i[0], "R8 alternate");
        // Random mix of enable and direction.
        for (int i = 0; i < 400; i++)
            drive(($urandom % 4) != 0, $urandom % 2, "R2 R3 R6 random");
        // R1: reset again from a non-zero value.
        drive(1, 1, "R2 pre-reset");
        rst_n = 1'b0;
        check("R1 reset midrun");
        rst_n = 1'b1;
        drive(1, 0, "R3 after reset");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule